// File: doc/BRIEF.md
# Two-Master Grab-Window Arbiter

This block decides which of two requesting subsystems, A and B, drives a single shared external-bus port. With no grab in force the two are served in turn: each granted transfer hands priority to the other master, and master A wins the first tie after reset. Only one transfer is in flight at a time. A granted transfer holds `bus_valid` and `bus_sel` until the downstream port reports completion on `bus_done`. In that same cycle the owner's acknowledge goes high.

Subsystem B can take exclusive ownership by writing the grab bit. While the grab holds, A is never granted; its requests simply wait. A transfer from A that was already running when the grab came in finishes normally first. A window counter runs for as long as the grab holds and is bounded by a programmable period. If software has not cleared the grab by the time the counter reaches the period, the hardware clears it, sets a sticky timeout flag and raises the interrupt, provided the interrupt is enabled. Releasing the grab early raises nothing.

Register writes use a small port. Address 0 is the control word: bit 0 is the grab bit and bit 1 is the interrupt enable. Address 1 is the period. Address 2 is the status word: writing a one to bit 0 clears the timeout flag.

Top module: `grab_arbiter`

## Requirements
- R1: With the grab clear and both masters requesting, grants alternate between the masters. After reset the first tie goes to master A (`bus_sel`=0). Priority passes to the other master after every completed transfer, and a lone requester is served back to back.
- R2: A granted transfer keeps `bus_valid` high and `bus_sel` steady until `bus_done`. The owner's acknowledge is high in the `bus_done` cycle and the other acknowledge stays low.
- R3: While the grab is active (`grab_active`=1), master A is not granted and its requests wait. Master B is served as usual.
- R4: A transfer from A that is in progress when the grab is set completes with its acknowledge. B is then granted ahead of any further A request.
- R5: The window counter is zero while no grab is active and advances once per cycle while it is active. A timeout occurs when the counter reaches or exceeds the period, so an unreleased grab stays high for period+1 cycles. A period of 0 gives one cycle.
- R6: On timeout the hardware clears the grab bit and sets `timeout_flag`.
- R7: Writing control bit 0 to zero before the timeout releases the grab, and `timeout_flag` is left unchanged.
- R8: `irq` is high exactly when `timeout_flag` is set and the interrupt enable (control bit 1) is set.
- R9: `timeout_flag` is sticky. A status write (address 2) with bit 0 set clears it, and a status write with bit 0 clear leaves it set.
- R10: Every new grab restarts the window counter from zero. A grab released and set again runs a full period+1 cycles.
- R11: After reset no transfer is active, both acknowledges are low, the grab, flag and interrupt are clear, and the interrupt enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_req | input | 1 | Master A transfer request, held until `a_ack` |
| a_ack | output | 1 | Master A transfer completed this cycle |
| b_req | input | 1 | Master B transfer request, held until `b_ack` |
| b_ack | output | 1 | Master B transfer completed this cycle |
| bus_valid | output | 1 | A transfer is being driven on the shared port |
| bus_sel | output | 1 | Owner of the current transfer: 0 = A, 1 = B |
| bus_done | input | 1 | Downstream port finishes the current transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 period, 2 status |
| reg_wdata | input | PW | Register write data |
| grab_active | output | 1 | Grab bit currently set |
| timeout_flag | output | 1 | Sticky timeout status |
| irq | output | 1 | Timeout interrupt to master B |

## Verification
The checker assumes that each master holds its request from assertion until its acknowledge, and that `bus_done` arrives only while `bus_valid` is high. It also assumes the period is not rewritten while a grab is held, since the window-length property compares against the current period. The bench keeps to these assumptions by construction. Its master models drop a request only in the cycle after the matching acknowledge. Its port model raises `bus_done` only a fixed number of cycles into a visible transfer. Every period write is placed where the grab is clear.

// File: rtl/grab_arb_pkg.sv
// Shared definitions for the two-master grab-window arbiter.
// Assumes a two-bit register address space; holds the owner encoding,
// register addresses and the bit positions inside the control and status words.
package grab_arb_pkg;

    typedef enum logic {
        OWN_A = 1'b0,
        OWN_B = 1'b1
    } owner_e;

    localparam int NUM_MASTERS = 2;
    localparam int ADDR_W      = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT   = 2'd2;

    localparam int CTRL_GRAB_BIT = 0;
    localparam int CTRL_IEN_BIT  = 1;
    localparam int STAT_TO_BIT   = 0;

endpackage

// File: rtl/grab_arb_regs.sv
// Register file for the grab window: the grab bit, the interrupt enable,
// the period and the sticky timeout flag.
// Assumes one write per cycle. A timeout wins over a simultaneous software
// write of the grab bit, and setting the flag wins over clearing it.
module grab_arb_regs
    import grab_arb_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PW-1:0]     wdata,
    input  logic              timeout,
    output logic              grab,
    output logic              ien,
    output logic [PW-1:0]     period,
    output logic              flag
);

    logic wr_ctrl;
    logic wr_period;
    logic wr_stat;

    // Decode the single write strobe per register.
    always_comb begin
        wr_ctrl   = wr && (addr == ADDR_CTRL);
        wr_period = wr && (addr == ADDR_PERIOD);
        wr_stat   = wr && (addr == ADDR_STAT);
    end

    // Grab bit: hardware release on timeout, otherwise software controlled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grab <= 1'b0;
        end else if (timeout) begin
            grab <= 1'b0;
        end else if (wr_ctrl) begin
            grab <= wdata[CTRL_GRAB_BIT];
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
        end else if (wr_ctrl) begin
            ien <= wdata[CTRL_IEN_BIT];
        end
    end

    // Window period, reset to the longest window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '1;
        end else if (wr_period) begin
            period <= wdata;
        end
    end

    // Sticky timeout flag, cleared by writing one to its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (timeout) begin
            flag <= 1'b1;
        end else if (wr_stat && wdata[STAT_TO_BIT]) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/grab_arb_window.sv
// Window counter for the grab. It is zero while no grab is held and counts
// cycles while one is. The timeout fires once the count reaches the period.
// Assumes the grab drops in the cycle after a timeout, which the register
// file guarantees.
module grab_arb_window #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grab,
    input  logic [PW-1:0] period,
    output logic          timeout
);

    logic [PW-1:0] count;

    // Timeout request: the window has used up its period.
    always_comb begin
        timeout = grab && (count >= period);
    end

    // Count cycles of an active grab, restarting from zero after each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!grab || timeout) begin
            count <= '0;
        end else begin
            count <= count + PW'(1);
        end
    end

endmodule

// File: rtl/grab_arb_core.sv
// Round-robin grant engine for the shared port. One transfer is in flight
// at a time. While the grab holds, master A is not eligible. Priority passes
// to the other master when each transfer completes.
// Assumes requests are held until acknowledged and that done arrives only
// while a transfer is active.
module grab_arb_core
    import grab_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   grab,
    input  logic                   done,
    output logic                   busy,
    output owner_e                 owner,
    output logic [NUM_MASTERS-1:0] ack
);

    logic [NUM_MASTERS-1:0] eligible;
    logic                   pick_valid;
    owner_e                 pick;
    owner_e                 favoured;

    // Mask master A while the grab is held.
    always_comb begin
        eligible         = req;
        eligible[OWN_A]  = req[OWN_A] && !grab;
        pick_valid       = |eligible;
    end

    // Choose the next owner, using the favoured master to break a tie.
    always_comb begin
        if (&eligible) begin
            pick = favoured;
        end else if (eligible[OWN_B]) begin
            pick = OWN_B;
        end else begin
            pick = OWN_A;
        end
    end

    // Transfer state: start at an idle arbitration point, end on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            owner <= OWN_A;
        end else if (!busy && pick_valid) begin
            busy  <= 1'b1;
            owner <= pick;
        end else if (busy && done) begin
            busy  <= 1'b0;
        end
    end

    // Round-robin pointer: favour the master that did not just finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            favoured <= OWN_A;
        end else if (busy && done) begin
            favoured <= (owner == OWN_A) ? OWN_B : OWN_A;
        end
    end

    // Per-master completion acknowledges.
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_ack
        assign ack[i] = busy && done && (owner == ((i == 0) ? OWN_A : OWN_B));
    end

endmodule

// File: rtl/grab_arbiter.sv
// Top of the two-master grab-window arbiter. It connects the register file,
// the window counter and the grant engine, and maps the per-master
// handshakes onto the shared port.
// Assumes a single clock domain and a synchronous active-low reset.
module grab_arbiter
    import grab_arb_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    output logic              a_ack,
    input  logic              b_req,
    output logic              b_ack,
    output logic              bus_valid,
    output logic              bus_sel,
    input  logic              bus_done,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PW-1:0]     reg_wdata,
    output logic              grab_active,
    output logic              timeout_flag,
    output logic              irq
);

    logic                   grab_q;
    logic                   ien_q;
    logic [PW-1:0]          period_q;
    logic                   flag_q;
    logic                   timeout;
    logic                   busy;
    owner_e                 owner;
    logic [NUM_MASTERS-1:0] req_vec;
    logic [NUM_MASTERS-1:0] ack_vec;

    // Gather the requests into a vector indexed by owner.
    always_comb begin
        req_vec[OWN_A] = a_req;
        req_vec[OWN_B] = b_req;
    end

    grab_arb_regs #(.PW(PW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .timeout (timeout),
        .grab    (grab_q),
        .ien     (ien_q),
        .period  (period_q),
        .flag    (flag_q)
    );

    grab_arb_window #(.PW(PW)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .grab    (grab_q),
        .period  (period_q),
        .timeout (timeout)
    );

    grab_arb_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_vec),
        .grab  (grab_q),
        .done  (bus_done),
        .busy  (busy),
        .owner (owner),
        .ack   (ack_vec)
    );

    // Drive the port, acknowledge and status outputs.
    always_comb begin
        bus_valid    = busy;
        bus_sel      = (owner == OWN_B);
        a_ack        = ack_vec[OWN_A];
        b_ack        = ack_vec[OWN_B];
        grab_active  = grab_q;
        timeout_flag = flag_q;
        irq          = flag_q && ien_q;
    end

endmodule

// File: rtl/grab_arbiter_chk.sv
// Property checker for the grab-window arbiter, attached by bind.
// It keeps its own window length counter and the owner of the last
// completed transfer.
// Assumes requests are held until acknowledged and that the period is not
// rewritten while a grab is held.
module grab_arbiter_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_req,
    input logic          b_req,
    input logic          a_ack,
    input logic          b_ack,
    input logic          bus_valid,
    input logic          bus_sel,
    input logic          bus_done,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [PW-1:0] reg_wdata,
    input logic          grab_active,
    input logic          timeout_flag,
    input logic [PW-1:0] period_q
);

    logic [PW-1:0] win_cycles;
    logic          last_own;
    logic          ctrl_release;
    logic          stat_clear;

    // Decode the software writes that the properties depend on.
    always_comb begin
        ctrl_release = reg_wr && (reg_addr == 2'd0) && !reg_wdata[0];
        stat_clear   = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];
    end

    // Count the cycles of the current grab, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || !grab_active) begin
            win_cycles <= '0;
        end else if (win_cycles != '1) begin
            win_cycles <= win_cycles + PW'(1);
        end
    end

    // Remember which master finished last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_own <= 1'b1;
        end else if (bus_valid && bus_done) begin
            last_own <= bus_sel;
        end
    end

    // R1
    rr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && a_req && b_req && !grab_active) |=> (bus_valid && bus_sel != last_own));

    // R2
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_sel)));

    // R2
    ack_ends_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack || b_ack) |=> !bus_valid);

    // R2
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ack && b_ack));

    // R3
    grab_blocks_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grab_active && !bus_valid) |=> !(bus_valid && !bus_sel));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grab_active |-> (win_cycles <= period_q));

    // R6
    timeout_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grab_active) && !$past(ctrl_release)) |-> timeout_flag);

    // R7
    early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(grab_active) && $past(ctrl_release) && ($past(win_cycles) < $past(period_q)))
        |-> (timeout_flag == $past(timeout_flag)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout_flag) && !$past(stat_clear)) |-> timeout_flag);

    // R2
    done_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done |-> bus_valid);

endmodule

bind grab_arbiter grab_arbiter_chk #(.PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_req        (a_req),
    .b_req        (b_req),
    .a_ack        (a_ack),
    .b_ack        (b_ack),
    .bus_valid    (bus_valid),
    .bus_sel      (bus_sel),
    .bus_done     (bus_done),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .grab_active  (grab_active),
    .timeout_flag (timeout_flag),
    .period_q     (period_q)
);

// File: tb/sim_grab_arbiter.sv
module sim_grab_arbiter;

    localparam int PW  = 16;
    localparam int LAT = 2;

    logic          clk;
    logic          rst_n;
    logic          a_req, b_req, a_ack, b_ack;
    logic          bus_valid, bus_sel, bus_done;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [PW-1:0] reg_wdata;
    logic          grab_active, timeout_flag, irq;

    int    checks   = 0;
    int    failures = 0;
    int    a_pend   = 0;
    int    b_pend   = 0;
    int    lat      = 0;
    bit    finished = 0;
    string cur_tag  = "R1";
    logic  exp_q[$];

    grab_arbiter #(.PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_ack(a_ack), .b_req(b_req), .b_ack(b_ack),
        .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_done(bus_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .grab_active(grab_active), .timeout_flag(timeout_flag), .irq(irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [PW-1:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        #2;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 500; i++) begin
            if (a_pend == 0 && b_pend == 0 && !bus_valid && !a_req && !b_req) break;
            step(1);
        end
    endtask

    task automatic window_len(output int n);
        n = 0;
        while (grab_active && n < 200) begin
            n++;
            step(1);
        end
    endtask

    // Master and port model with the scoreboard monitor.
    initial begin
        a_req    = 1'b0;
        b_req    = 1'b0;
        bus_done = 1'b0;
        forever begin
            @(negedge clk);
            a_req    = (a_pend > 0);
            b_req    = (b_pend > 0);
            bus_done = 1'b0;
            if (bus_valid && rst_n) begin
                if (lat == 0) begin
                    if (exp_q.size() == 0) begin
                        chk({cur_tag, " unexpected grant"}, int'(bus_sel), 2);
                    end else begin
                        chk({cur_tag, " grant order"}, int'(bus_sel), int'(exp_q.pop_front()));
                    end
                end
                if (lat == LAT) begin
                    bus_done = 1'b1;
                    lat = 0;
                    #1;
                    chk("R2 owner ack", bus_sel ? int'(b_ack) : int'(a_ack), 1);
                    chk("R2 other ack", bus_sel ? int'(a_ack) : int'(b_ack), 0);
                    if (bus_sel) b_pend--; else a_pend--;
                end else begin
                    lat++;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int n;
        reg_wr    = 1'b0;
        reg_addr  = 2'd0;
        reg_wdata = '0;
        rst_n     = 1'b0;
        step(4);
        // R11 reset state
        chk("R11 bus_valid", int'(bus_valid), 0);
        chk("R11 a_ack", int'(a_ack), 0);
        chk("R11 b_ack", int'(b_ack), 0);
        chk("R11 grab", int'(grab_active), 0);
        chk("R11 flag", int'(timeout_flag), 0);
        chk("R11 irq", int'(irq), 0);
        rst_n = 1'b1;
        step(2);

        // R1 contention: A first, then alternating
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(1'b0);
            exp_q.push_back(1'b1);
        end
        a_pend = 3; b_pend = 3;
        wait_drain();
        // R1 lone requester served back to back
        exp_q.push_back(1'b0); exp_q.push_back(1'b0);
        a_pend = 2;
        wait_drain();
        // R1 tie after an A transfer goes to B
        exp_q.push_back(1'b1); exp_q.push_back(1'b0);
        a_pend = 1; b_pend = 1;
        wait_drain();
        chk("R1 queue drained", exp_q.size(), 0);

        // R3 grab stalls A, B served, then R7 early release
        cur_tag = "R3";
        wr(2'd1, 16'd40);
        wr(2'd0, 16'h0003);
        chk("R3 grab set", int'(grab_active), 1);
        exp_q.push_back(1'b1); exp_q.push_back(1'b1);
        a_pend = 2; b_pend = 2;
        for (int i = 0; i < 30 && b_pend > 0; i++) step(1);
        step(4);
        chk("R3 A still waiting", a_pend, 2);
        chk("R3 port idle", int'(bus_valid), 0);
        chk("R3 grab held", int'(grab_active), 1);
        exp_q.push_back(1'b0); exp_q.push_back(1'b0);
        cur_tag = "R7";
        wr(2'd0, 16'h0002);
        chk("R7 grab released", int'(grab_active), 0);
        step(3);
        chk("R7 no flag", int'(timeout_flag), 0);
        chk("R7 no irq", int'(irq), 0);
        wait_drain();
        chk("R7 A served", a_pend, 0);

        // R5 / R6 / R8 timeout after period+1 cycles
        cur_tag = "R5";
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0003);
        window_len(n);
        chk("R5 window length period 5", n, 6);
        chk("R6 grab cleared", int'(grab_active), 0);
        chk("R6 flag set", int'(timeout_flag), 1);
        chk("R8 irq with enable", int'(irq), 1);
        wr(2'd0, 16'h0000);
        chk("R8 irq masked", int'(irq), 0);
        chk("R8 flag kept", int'(timeout_flag), 1);
        wr(2'd0, 16'h0002);
        chk("R8 irq re-enabled", int'(irq), 1);
        // R9 write zero does nothing, write one clears
        wr(2'd2, 16'h0000);
        chk("R9 write zero keeps flag", int'(timeout_flag), 1);
        wr(2'd2, 16'h0001);
        chk("R9 w1c clears flag", int'(timeout_flag), 0);
        chk("R9 irq drops", int'(irq), 0);

        // R5 period zero: one cycle
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        window_len(n);
        chk("R5 window length period 0", n, 1);
        chk("R6 flag after zero period", int'(timeout_flag), 1);
        wr(2'd2, 16'h0001);

        // R4 A in progress when grab arrives completes, then B
        cur_tag = "R4";
        wr(2'd1, 16'd60);
        exp_q.push_back(1'b0); exp_q.push_back(1'b1);
        a_pend = 1;
        for (int i = 0; i < 20 && !bus_valid; i++) step(1);
        chk("R4 A in flight", int'(bus_valid && !bus_sel), 1);
        b_pend = 1;
        wr(2'd0, 16'h0001);
        for (int i = 0; i < 30 && (a_pend > 0 || b_pend > 0); i++) step(1);
        chk("R4 A completed", a_pend, 0);
        chk("R4 B completed", b_pend, 0);
        a_pend = 1;
        step(10);
        chk("R4 later A stalled", a_pend, 1);
        exp_q.push_back(1'b0);
        wr(2'd0, 16'h0000);
        wait_drain();
        chk("R4 queue drained", exp_q.size(), 0);

        // R10 re-grab restarts the window counter
        cur_tag = "R10";
        wr(2'd1, 16'd8);
        wr(2'd0, 16'h0001);
        step(3);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0001);
        window_len(n);
        chk("R10 full window after re-grab", n, 9);
        chk("R10 flag", int'(timeout_flag), 1);

        step(3);
        chk("final queue empty", exp_q.size(), 0);
        summary();
    end

endmodule